// File: doc/BRIEF.md
# Shift-and-Add Multiply Step Unit

This block performs one step of a shift-and-add multiplication per clock. It holds a multiplier shift register (Y) and a set of four condition flags: negative, zero, overflow and carry. On each step it forms a first addend from the incoming partial product, shifted right by one place. The new top bit of that addend is the exclusive-or of the stored negative and overflow flags. When bit 0 of Y is set, the multiplicand is added to this addend. The 32-bit sum is registered, the flags are refreshed from the addition, and the bit that dropped off the partial product enters the top of Y. The sum, Y and the flags all change on the same clock edge.

Steps can be issued one at a time through a direct port. A small sequencer can also run a complete multiplication. It loads Y with the multiplier and clears the partial product and the flags. It then issues 32 steps with the multiplicand and a final step with a zero addend. The 64-bit result appears as {partial product, Y}. No sign correction is applied, so the result is the multiplicand taken as two's complement times the multiplier taken as unsigned.

Top module: `mstep_unit`

## Requirements
- R1: After a synchronous active-low reset, step_sum, y_rdata and flags are all zero, and mul_busy and mul_done are low.
- R2: A direct step (step_go high while idle, with y_wr and mul_start low) adds A = {n XOR v, step_part[31:1]} and B (step_mcand when Y[0] is 1, otherwise zero). The 32-bit result is presented on step_sum after that clock edge.
- R3: On a step, Y becomes {step_part[0], Y[31:1]} on the same edge as the sum.
- R4: After a step, flags[3] (n) equals bit 31 of the sum and flags[2] (z) is 1 exactly when the sum is zero. The flags field order is {n, z, v, c}.
- R5: After a step, flags[1] (v) is set when A and B have equal sign bits and the sum's sign bit differs from them. flags[0] (c) is the carry out of bit 31 of A + B.
- R6: A step uses the n and v values held before that step, not the ones it produces.
- R7: y_wr while idle (mul_start low) loads y_wdata into Y, which then reads back on y_rdata. step_sum and flags are left unchanged.
- R8: When y_wr and step_go are both high while idle, the load wins and no step is performed: step_sum and flags stay as they were.
- R9: An accepted mul_start holds mul_busy high for exactly 33 cycles. mul_done then pulses high for one cycle, in the first cycle with mul_busy low.
- R10: When mul_done is high, {mul_hi, mul_lo} equals the 64-bit two's-complement product of mul_mcand (signed) and mul_mplier (unsigned).
- R11: While mul_busy is high, step_go, y_wr and mul_start are ignored, and the running product is unaffected.
- R12: mul_start clears the flags, so the product does not depend on the n and v values left by earlier steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_go | input | 1 | Perform one direct step |
| step_part | input | 32 | Partial product for a direct step |
| step_mcand | input | 32 | Multiplicand for a direct step |
| step_sum | output | 32 | Registered sum of the last step |
| y_wr | input | 1 | Load Y |
| y_wdata | input | 32 | Value loaded into Y |
| y_rdata | output | 32 | Current Y |
| flags | output | 4 | Condition flags {n, z, v, c} |
| mul_start | input | 1 | Begin a full multiplication |
| mul_mcand | input | 32 | Multiplicand (two's complement) |
| mul_mplier | input | 32 | Multiplier (unsigned) |
| mul_busy | output | 1 | Sequence in progress |
| mul_done | output | 1 | One-cycle result-valid pulse |
| mul_hi | output | 32 | Upper product word |
| mul_lo | output | 32 | Lower product word |

## Verification
Direct steps are chosen to produce each flag outcome on its own. One step overflows to a negative sum. Another gives a negative sum without overflow. A third wraps to zero with a carry. The step after the negative sum shows whether the stored n XOR v, or the new sign, feeds the top bit. Full multiplications use zero, one and all-ones operands, the most negative multiplicand, a multiplier with only its top bit set, and mixed patterns. Together these separate the signed handling of the shifted partial product from plain unsigned addition. Further runs start after flags have been left with n XOR v set, or are disturbed by port activity mid-sequence, to expose a missing flag clear or a missing busy lockout.

// File: rtl/mstep_pkg.sv
// Shared types for the multiply-step unit.
// Assumes: flags are always handled in the order {n, z, v, c}.
package mstep_pkg;
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccode_t;
endpackage

// File: rtl/mstep_alu.sv
// Combinational step datapath: forms both addends, adds them and derives flags.
// Assumes: n_in/v_in are the flags held before the step.
module mstep_alu
    import mstep_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] part,
    input  logic [DW-1:0] mcand,
    input  logic          y_lsb,
    input  logic          n_in,
    input  logic          v_in,
    output logic [DW-1:0] sum,
    output ccode_t        cc,
    output logic          out_bit
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] opa;
    logic [DW-1:0] opb;

    // Build addends and result flags.
    always_comb begin
        opa     = {n_in ^ v_in, part[MSB:1]};
        opb     = y_lsb ? mcand : '0;
        sum     = opa + opb;
        out_bit = part[0];
        cc.n    = sum[MSB];
        cc.z    = (sum == '0);
        cc.v    = (opa[MSB] & opb[MSB] & ~sum[MSB]) | (~opa[MSB] & ~opb[MSB] & sum[MSB]);
        cc.c    = (opa[MSB] & opb[MSB]) | (~sum[MSB] & (opa[MSB] | opb[MSB]));
    end
endmodule

// File: rtl/mstep_regs.sv
// State of the unit: Y shift register, flags and registered sum.
// Assumes: the caller never asserts more than one of init, y_ld, step_en.
module mstep_regs
    import mstep_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          y_ld,
    input  logic [DW-1:0] y_val,
    input  logic          step_en,
    input  logic [DW-1:0] sum_in,
    input  ccode_t        cc_in,
    input  logic          shift_bit,
    output logic [DW-1:0] sum_q,
    output ccode_t        cc_q,
    output logic [DW-1:0] y_q
);
    localparam int MSB = DW - 1;

    // Update sum, flags and Y together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cc_q  <= '0;
            y_q   <= '0;
        end else if (init) begin
            sum_q <= '0;
            cc_q  <= '0;
            y_q   <= y_val;
        end else if (y_ld) begin
            y_q   <= y_val;
        end else if (step_en) begin
            sum_q <= sum_in;
            cc_q  <= cc_in;
            y_q   <= {shift_bit, y_q[MSB:1]};
        end
    end
endmodule

// File: rtl/mstep_seq.sv
// Sequencer: on start runs DW steps with the multiplicand and one with zero.
// Assumes: start is only raised when the sequencer is idle.
module mstep_seq #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] mcand,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] step_mcand
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    logic [CW-1:0] cnt;
    logic [DW-1:0] mcand_q;

    // Step counter, busy and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            mcand_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt     <= '0;
                busy    <= 1'b1;
                mcand_q <= mcand;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Final step adds zero.
    always_comb step_mcand = (cnt == LAST) ? '0 : mcand_q;
endmodule

// File: rtl/mstep_unit.sv
// Top: multiply-step unit with direct step port and full-multiply sequencer.
// Assumes: port priority when idle is mul_start, then y_wr, then step_go.
module mstep_unit
    import mstep_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_go,
    input  logic [DW-1:0] step_part,
    input  logic [DW-1:0] step_mcand,
    output logic [DW-1:0] step_sum,
    input  logic          y_wr,
    input  logic [DW-1:0] y_wdata,
    output logic [DW-1:0] y_rdata,
    output logic [3:0]    flags,
    input  logic          mul_start,
    input  logic [DW-1:0] mul_mcand,
    input  logic [DW-1:0] mul_mplier,
    output logic          mul_busy,
    output logic          mul_done,
    output logic [DW-1:0] mul_hi,
    output logic [DW-1:0] mul_lo
);
    logic          accept, ywr_ok, step_en;
    logic [DW-1:0] seq_mcand, op_part, op_mcand, alu_sum, sum_q, y_q, y_val;
    logic          shift_bit;
    ccode_t        alu_cc, cc_q;

    // Arbitrate the port requests.
    always_comb begin
        accept   = mul_start & ~mul_busy;
        ywr_ok   = y_wr & ~mul_busy & ~mul_start;
        step_en  = mul_busy | (step_go & ~mul_start & ~y_wr);
        y_val    = accept ? mul_mplier : y_wdata;
        op_part  = mul_busy ? sum_q : step_part;
        op_mcand = mul_busy ? seq_mcand : step_mcand;
    end

    mstep_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .mcand(mul_mcand),
        .busy(mul_busy), .done(mul_done), .step_mcand(seq_mcand)
    );

    mstep_alu #(.DW(DW)) u_alu (
        .part(op_part), .mcand(op_mcand), .y_lsb(y_q[0]),
        .n_in(cc_q.n), .v_in(cc_q.v),
        .sum(alu_sum), .cc(alu_cc), .out_bit(shift_bit)
    );

    mstep_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .init(accept), .y_ld(ywr_ok), .y_val(y_val),
        .step_en(step_en), .sum_in(alu_sum), .cc_in(alu_cc), .shift_bit(shift_bit),
        .sum_q(sum_q), .cc_q(cc_q), .y_q(y_q)
    );

    // Drive outputs from the state.
    always_comb begin
        step_sum = sum_q;
        y_rdata  = y_q;
        flags    = cc_q;
        mul_hi   = sum_q;
        mul_lo   = y_q;
    end
endmodule

// File: rtl/mstep_chk.sv
// Checker for mstep_unit, attached by bind; observes ports only.
// Assumes: DW is small enough for a plain busy-length counter.
module mstep_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_go,
    input logic [DW-1:0] step_part,
    input logic          y_wr,
    input logic [DW-1:0] y_wdata,
    input logic          mul_start,
    input logic          mul_busy,
    input logic          mul_done,
    input logic [DW-1:0] y_rdata,
    input logic [3:0]    flags,
    input logic [DW-1:0] step_sum
);
    logic [7:0] bcnt;
    logic       idle_step;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        bcnt <= '0;
        else if (mul_busy) bcnt <= bcnt + 1'b1;
        else               bcnt <= '0;
    end

    // Direct step request seen at the ports.
    always_comb idle_step = step_go & ~y_wr & ~mul_start & ~mul_busy;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (step_sum == '0 && y_rdata == '0 && flags == 4'b0 && !mul_busy && !mul_done));

    a_r3_y_shift: assert property (@(posedge clk) disable iff (!rst_n)
        idle_step |=> y_rdata == {$past(step_part[0]), $past(y_rdata[DW-1:1])});

    a_r4_nz_flags: assert property (@(posedge clk) disable iff (!rst_n)
        idle_step |=> (flags[3] == step_sum[DW-1]) && (flags[2] == (step_sum == '0)));

    a_r7_y_load: assert property (@(posedge clk) disable iff (!rst_n)
        (y_wr && !mul_busy && !mul_start) |=> (y_rdata == $past(y_wdata)) && $stable(flags));

    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (y_wr && step_go && !mul_busy && !mul_start) |=> $stable(step_sum));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |=> !mul_done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |-> !mul_busy);

    a_r9_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= 8'(DW + 1));
endmodule

bind mstep_unit mstep_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .step_part(step_part),
    .y_wr(y_wr), .y_wdata(y_wdata), .mul_start(mul_start), .mul_busy(mul_busy),
    .mul_done(mul_done), .y_rdata(y_rdata), .flags(flags), .step_sum(step_sum)
);

// File: tb/sim_mstep_unit.sv
`timescale 1ns/1ps
module sim_mstep_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_go = 1'b0, y_wr = 1'b0, mul_start = 1'b0;
    logic [31:0] step_part = '0, step_mcand = '0, y_wdata = '0, mul_mcand = '0, mul_mplier = '0;
    logic [31:0] step_sum, y_rdata, mul_hi, mul_lo;
    logic [3:0]  flags;
    logic        mul_busy, mul_done;

    int checks = 0;
    int fails  = 0;

    // Bench model of the architectural state.
    logic [31:0] m_y = '0, m_sum = '0;
    logic        m_n = 0, m_z = 0, m_v = 0, m_c = 0;

    localparam int NV = 8;
    localparam logic [63:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'h0000_0001, 32'h0000_0001},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'hFFFF_FFFF},
        {32'h7FFF_FFFF, 32'h7FFF_FFFF},
        {32'h1234_5678, 32'h9ABC_DEF0},
        {32'hDEAD_BEEF, 32'h0000_0002},
        {32'h0000_0003, 32'h8000_0000}
    };

    always #2.5 clk = ~clk;

    mstep_unit u0 (
        .clk(clk), .rst_n(rst_n), .step_go(step_go), .step_part(step_part),
        .step_mcand(step_mcand), .step_sum(step_sum), .y_wr(y_wr), .y_wdata(y_wdata),
        .y_rdata(y_rdata), .flags(flags), .mul_start(mul_start), .mul_mcand(mul_mcand),
        .mul_mplier(mul_mplier), .mul_busy(mul_busy), .mul_done(mul_done),
        .mul_hi(mul_hi), .mul_lo(mul_lo)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] m, input logic [31:0] x);
        logic signed [63:0] a, b;
        a = {{32{m[31]}}, m};
        b = {32'b0, x};
        return 64'(a * b);
    endfunction

    // One direct step, checked against the model (R2 R3 R4 R5 R6).
    task automatic step(input logic [31:0] p, input logic [31:0] m);
        logic [31:0] a, b, r;
        logic        co;
        a = {m_n ^ m_v, p[31:1]};
        b = m_y[0] ? m : 32'h0;
        {co, r} = {1'b0, a} + {1'b0, b};
        m_v = (a[31] == b[31]) && (r[31] != a[31]);
        m_c = co;
        m_n = r[31];
        m_z = (r == 0);
        m_sum = r;
        m_y = {p[0], m_y[31:1]};
        @(negedge clk); step_go = 1; step_part = p; step_mcand = m;
        @(negedge clk); step_go = 0;
        chk("R2 R6 step sum", 64'(step_sum), 64'(m_sum));
        chk("R3 Y shift", 64'(y_rdata), 64'(m_y));
        chk("R4 n z flags", 64'(flags[3:2]), 64'({m_n, m_z}));
        chk("R5 v c flags", 64'(flags[1:0]), 64'({m_v, m_c}));
    endtask

    task automatic ywrite(input logic [31:0] d);
        m_y = d;
        @(negedge clk); y_wr = 1; y_wdata = d;
        @(negedge clk); y_wr = 0;
        chk("R7 Y load", 64'(y_rdata), 64'(d));
        chk("R7 flags and sum kept", {28'b0, flags, step_sum}, {28'b0, m_n, m_z, m_v, m_c, m_sum});
    endtask

    // Full multiply; disturb=1 pokes the ports while busy (R11).
    task automatic run_mul(input logic [31:0] m, input logic [31:0] x, input bit disturb, input string tag);
        int nb;
        nb = 0;
        @(negedge clk); mul_start = 1; mul_mcand = m; mul_mplier = x;
        @(negedge clk); mul_start = 0; mul_mcand = ~m; mul_mplier = ~x;
        while (mul_busy && nb < 40) begin
            nb++;
            if (disturb && nb == 5) begin
                step_go = 1; y_wr = 1; mul_start = 1; y_wdata = 32'h1357_9BDF; step_part = 32'hFFFF_FFFF;
                step_mcand = 32'h0F0F_0F0F;
            end else begin
                step_go = 0; y_wr = 0; mul_start = 0;
            end
            @(negedge clk);
        end
        step_go = 0; y_wr = 0; mul_start = 0;
        chk("R9 busy length", 64'(nb), 64'd33);
        chk("R9 done pulse", 64'(mul_done), 64'd1);
        chk(tag, {mul_hi, mul_lo}, ref_prod(m, x));
        @(negedge clk);
        chk("R9 done drops", 64'(mul_done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk("R1 reset state", {step_sum, y_rdata}, 64'h0);
        chk("R1 reset flags/busy/done", {58'b0, flags, mul_busy, mul_done}, 64'h0);

        ywrite(32'h0000_0003);
        step(32'hFFFF_FFFE, 32'h0000_0001);   // R5 overflow into negative
        ywrite(32'h0000_0003);                 // R7 flags survive
        step(32'h0000_0000, 32'h8000_0001);   // negative, no overflow
        step(32'hFFFF_FFFE, 32'h0000_0001);   // R6 top bit from old n^v, R5 carry, zero
        step(32'h0000_0001, 32'h0000_0055);   // Y[0]=0: addend zero

        // R8 load wins over step
        m_y = 32'hA5A5_A5A5;
        @(negedge clk); y_wr = 1; step_go = 1; y_wdata = 32'hA5A5_A5A5; step_part = 32'h1234_5678; step_mcand = 32'hFFFF_FFFF;
        @(negedge clk); y_wr = 0; step_go = 0;
        chk("R8 Y loaded", 64'(y_rdata), 64'hA5A5_A5A5);
        chk("R8 no step", {28'b0, flags, step_sum}, {28'b0, m_n, m_z, m_v, m_c, m_sum});

        // R12: leave n^v = 1 then multiply
        step(32'h0000_0000, 32'h8000_0001);
        chk("R12 precondition n^v", 64'(flags[3] ^ flags[1]), 64'd1);
        run_mul(32'h0000_0007, 32'h0000_0009, 0, "R12 R10 product after dirty flags");

        for (int i = 0; i < NV; i++)
            run_mul(VEC[i][63:32], VEC[i][31:0], 0, "R10 product");

        run_mul(32'hCAFE_F00D, 32'hFEDC_BA98, 1, "R11 R10 product with port activity");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule